// File: doc/BRIEF.md
# Synchronous Trap Cause Selector

This block is purely combinational. It sits beside the commit point of a 32-bit RISC-V pipeline and gathers the synchronous fault conditions raised by three stages: fetch, decode and the memory stage. From them it produces three outputs:

- a single exception-valid flag;
- the 4-bit architectural exception code;
- the trap value that the trap-entry logic writes into its trap-value register.

Some conditions are derived inside the block from raw stage data: fetch-address alignment, data-address alignment against the access size, and qualification of the data-cache error by access direction. The remaining conditions arrive as ready-made flags. A compile-time parameter selects whether compressed instructions are supported, which relaxes the fetch alignment rule to 2 bytes.

When several conditions are present at once, exactly one cause is reported. It is picked by a fixed priority order, and the trap value follows the chosen cause. The block holds no state, and it needs neither clock nor reset.

Top module: `excCauseDetector`

## Requirements
- R1: Fetch misalignment (code 0, trap value = fetch PC) is raised when fetchPc bit 0 is set. If the parameter COMPRESSED is 0, it is also raised when fetchPc bit 1 is set. With COMPRESSED = 1 (the default), a PC with only bit 1 set raises nothing.
- R2: Any of icacheErr, pmaExecErr or pmpExecErr raises an instruction access fault: code 1, trap value = fetch PC.
- R3: opcodeOk low, functBad high or csrBad high raises an illegal instruction: code 2, trap value = instrWord.
- R4: breakHit raises a breakpoint: code 3, trap value zero.
- R5: memSize encodes 0 = byte, 1 = halfword, 2 = word, 3 = reserved. Misalignment is judged as follows: a byte access is never misaligned; a halfword access is misaligned if memAddr bit 0 is set; a word access is misaligned if either of memAddr bits 1:0 is set; the reserved size is always misaligned. A misaligned access gives code 4 when isLoad is high, or code 6 when isStore is high. Neither code is raised when both isLoad and isStore are low.
- R6: dcacheErr gives a load access fault (code 5) with isLoad high, or a store access fault (code 7) with isStore high. It has no effect when both are low.
- R7: ecallHit raises an environment call whose code depends on privMode: 0 (user) gives code 8, 1 (supervisor) gives code 9, and 3 (machine) or the unused value 2 gives code 11. The trap value is zero.
- R8: Among simultaneous conditions, the reported cause is the first one in this order: fetch misaligned, instruction access fault, illegal instruction, breakpoint, load misaligned, load access fault, store misaligned, store access fault, environment call. When isLoad and isStore are both high, the load causes take their own higher places in this order.
- R9: The four data causes (codes 4 to 7) carry memAddr as trap value.
- R10: With no active condition, excValid is 0, excCode is 15 and excTval is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fetchPc | input | 32 | Address of the fetched instruction |
| icacheErr | input | 1 | Instruction cache or bus error on fetch |
| pmaExecErr | input | 1 | Fetch from a region not marked executable |
| pmpExecErr | input | 1 | Execute permission denied by protection unit |
| opcodeOk | input | 1 | Decoder recognised the opcode |
| functBad | input | 1 | Decoder rejected the function field |
| csrBad | input | 1 | CSR access not permitted |
| instrWord | input | 32 | Raw instruction bits |
| breakHit | input | 1 | Breakpoint instruction decoded |
| ecallHit | input | 1 | Environment call instruction decoded |
| privMode | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| memSize | input | 2 | Data access size: 0 byte, 1 half, 2 word, 3 reserved |
| memAddr | input | 32 | Effective data address |
| isLoad | input | 1 | Memory-stage instruction is a load |
| isStore | input | 1 | Memory-stage instruction is a store or AMO |
| dcacheErr | input | 1 | Data cache or bus error |
| excValid | output | 1 | An exception is reported |
| excCode | output | 4 | Exception code, 15 when none |
| excTval | output | 32 | Trap value for the reported cause |

## Verification
Because the block holds no state, a wrong selection appears on the ports in the same evaluation as the stimulus that causes it. A wrong selection is one of these: a misplaced priority rank, a dropped qualifier, or a mis-steered trap-value multiplexer. Each shows up as a wrong code, or as a trap value taken from the wrong source (PC, instruction word, address or zero).

Every pair of conditions is applied together, so any swap in the ordering is exposed. The alignment rules are exercised across every size encoding and low-address pattern, and idle inputs must leave the no-exception marker in place.

// File: rtl/excPkg.sv
package excPkg;

  localparam int XLEN       = 32;
  localparam int CODE_W     = 4;
  localparam int NUM_CAUSES = 9;

  localparam logic [CODE_W-1:0] CODE_NONE = 4'd15;

  // index of each cause in the priority vector, lowest index wins
  localparam int IDX_FETCH_MIS = 0;
  localparam int IDX_FETCH_ACC = 1;
  localparam int IDX_ILLEGAL   = 2;
  localparam int IDX_BREAK     = 3;
  localparam int IDX_LOAD_MIS  = 4;
  localparam int IDX_LOAD_ACC  = 5;
  localparam int IDX_STORE_MIS = 6;
  localparam int IDX_STORE_ACC = 7;
  localparam int IDX_ECALL     = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } memSizeE;

  typedef enum logic [1:0] {
    TV_ZERO,
    TV_PC,
    TV_INSTR,
    TV_ADDR
  } tvalSelE;

  typedef struct packed {
    logic               valid;
    tvalSelE            tvalSel;
    logic [CODE_W-1:0]  code;
  } excStrobeT;

  function automatic logic [CODE_W-1:0] ecallCode(input logic [1:0] priv);
    case (priv)
      2'd0:    return 4'd8;
      2'd1:    return 4'd9;
      default: return 4'd11;
    endcase
  endfunction

endpackage

// File: rtl/excDatapath.sv
module excDatapath
  import excPkg::*;
#(
  parameter int  ADDR_W     = XLEN,
  parameter bit  COMPRESSED = 1'b1
) (
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic [ADDR_W-1:0] instrWord,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [1:0]        memSize,
  input  excStrobeT         strobes,
  output logic              fetchMis,
  output logic              dataMis,
  output logic              excValid,
  output logic [CODE_W-1:0] excCode,
  output logic [ADDR_W-1:0] excTval
);

  memSizeE sizeE;
  assign sizeE = memSizeE'(memSize);

  generate
    if (COMPRESSED) begin : g_halfAlign
      assign fetchMis = fetchPc[0];
    end else begin : g_wordAlign
      assign fetchMis = |fetchPc[1:0];
    end
  endgenerate

  always_comb begin
    case (sizeE)
      SZ_BYTE: dataMis = 1'b0;
      SZ_HALF: dataMis = memAddr[0];
      SZ_WORD: dataMis = |memAddr[1:0];
      default: dataMis = 1'b1;
    endcase
  end

  always_comb begin
    case (strobes.tvalSel)
      TV_PC:    excTval = fetchPc;
      TV_INSTR: excTval = instrWord;
      TV_ADDR:  excTval = memAddr;
      default:  excTval = '0;
    endcase
  end

  assign excValid = strobes.valid;
  assign excCode  = strobes.code;

endmodule

// File: rtl/excControl.sv
module excControl
  import excPkg::*;
(
  input  logic       fetchMis,
  input  logic       dataMis,
  input  logic       icacheErr,
  input  logic       pmaExecErr,
  input  logic       pmpExecErr,
  input  logic       opcodeOk,
  input  logic       functBad,
  input  logic       csrBad,
  input  logic       breakHit,
  input  logic       ecallHit,
  input  logic [1:0] privMode,
  input  logic       isLoad,
  input  logic       isStore,
  input  logic       dcacheErr,
  output excStrobeT  strobes
);

  logic [NUM_CAUSES-1:0] cond;
  logic [CODE_W-1:0]     codeOf [NUM_CAUSES];
  tvalSelE               selOf  [NUM_CAUSES];

  always_comb begin
    cond                = '0;
    cond[IDX_FETCH_MIS] = fetchMis;
    cond[IDX_FETCH_ACC] = icacheErr | pmaExecErr | pmpExecErr;
    cond[IDX_ILLEGAL]   = ~opcodeOk | functBad | csrBad;
    cond[IDX_BREAK]     = breakHit;
    cond[IDX_LOAD_MIS]  = isLoad & dataMis;
    cond[IDX_LOAD_ACC]  = isLoad & dcacheErr;
    cond[IDX_STORE_MIS] = isStore & dataMis;
    cond[IDX_STORE_ACC] = isStore & dcacheErr;
    cond[IDX_ECALL]     = ecallHit;
  end

  generate
    for (genvar i = 0; i < NUM_CAUSES; i++) begin : g_table
      if (i == IDX_ECALL) begin : g_env
        assign codeOf[i] = ecallCode(privMode);
        assign selOf[i]  = TV_ZERO;
      end else begin : g_fault
        assign codeOf[i] = CODE_W'(i);
        assign selOf[i]  = (i <= IDX_FETCH_ACC) ? TV_PC :
                           (i == IDX_ILLEGAL)   ? TV_INSTR :
                           (i == IDX_BREAK)     ? TV_ZERO : TV_ADDR;
      end
    end
  endgenerate

  // scan from lowest priority upward so the lowest active index is kept
  always_comb begin
    strobes.valid   = 1'b0;
    strobes.tvalSel = TV_ZERO;
    strobes.code    = CODE_NONE;
    for (int k = NUM_CAUSES - 1; k >= 0; k--) begin
      if (cond[k]) begin
        strobes.valid   = 1'b1;
        strobes.tvalSel = selOf[k];
        strobes.code    = codeOf[k];
      end
    end
  end

endmodule

// File: rtl/excCauseDetector.sv
module excCauseDetector
  import excPkg::*;
#(
  parameter bit COMPRESSED = 1'b1
) (
  input  logic [31:0] fetchPc,
  input  logic        icacheErr,
  input  logic        pmaExecErr,
  input  logic        pmpExecErr,
  input  logic        opcodeOk,
  input  logic        functBad,
  input  logic        csrBad,
  input  logic [31:0] instrWord,
  input  logic        breakHit,
  input  logic        ecallHit,
  input  logic [1:0]  privMode,
  input  logic [1:0]  memSize,
  input  logic [31:0] memAddr,
  input  logic        isLoad,
  input  logic        isStore,
  input  logic        dcacheErr,
  output logic        excValid,
  output logic [3:0]  excCode,
  output logic [31:0] excTval
);

  logic      fetchMis;
  logic      dataMis;
  excStrobeT strobes;

  excControl u_ctrl (
    .fetchMis   (fetchMis),
    .dataMis    (dataMis),
    .icacheErr  (icacheErr),
    .pmaExecErr (pmaExecErr),
    .pmpExecErr (pmpExecErr),
    .opcodeOk   (opcodeOk),
    .functBad   (functBad),
    .csrBad     (csrBad),
    .breakHit   (breakHit),
    .ecallHit   (ecallHit),
    .privMode   (privMode),
    .isLoad     (isLoad),
    .isStore    (isStore),
    .dcacheErr  (dcacheErr),
    .strobes    (strobes)
  );

  excDatapath #(
    .ADDR_W     (32),
    .COMPRESSED (COMPRESSED)
  ) u_dp (
    .fetchPc   (fetchPc),
    .instrWord (instrWord),
    .memAddr   (memAddr),
    .memSize   (memSize),
    .strobes   (strobes),
    .fetchMis  (fetchMis),
    .dataMis   (dataMis),
    .excValid  (excValid),
    .excCode   (excCode),
    .excTval   (excTval)
  );

endmodule

// File: rtl/excCauseChecker.sv
module excCauseChecker (
  input logic [31:0] fetchPc,
  input logic        icacheErr,
  input logic        pmaExecErr,
  input logic        pmpExecErr,
  input logic        breakHit,
  input logic        isLoad,
  input logic        isStore,
  input logic        dcacheErr,
  input logic        excValid,
  input logic [3:0]  excCode,
  input logic [31:0] excTval
);

  always_comb begin
    a_r10_idle_marker: assert (excValid || (excCode == 4'd15 && excTval == '0))
      else $error("idle outputs not at marker");
    a_r7_legal_code: assert (!excValid || (excCode != 4'd15 && excCode != 4'd10 && excCode <= 4'd11))
      else $error("reported code outside legal set");
    a_r2_fetch_fault_wins: assert (!(icacheErr || pmaExecErr || pmpExecErr) || (excValid && excCode <= 4'd1))
      else $error("instruction access fault lost priority");
    a_r9_pc_tval: assert (!(excValid && excCode <= 4'd1) || excTval == fetchPc)
      else $error("fetch cause without PC trap value");
    a_r4_zero_tval: assert (!(excValid && (excCode == 4'd3 || excCode >= 4'd8)) || excTval == '0)
      else $error("non-zero trap value for breakpoint or ecall");
    a_r6_data_fault_seen: assert (!(dcacheErr && (isLoad || isStore)) || excValid)
      else $error("qualified data error not reported");
    a_r8_break_outranks_data: assert (!breakHit || (excValid && excCode <= 4'd3))
      else $error("breakpoint outranked by lower cause");
  end

endmodule

bind excCauseDetector excCauseChecker u_chk (.*);

// File: tb/excCauseDetector_tb.sv
module excCauseDetector_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PC_OK    = 32'h0000_1000;
  localparam logic [31:0] ADDR_OK  = 32'h0000_2000;
  localparam logic [31:0] INSTR_V  = 32'h00A5_8593;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] fetchPc, instrWord, memAddr;
  logic icacheErr, pmaExecErr, pmpExecErr, opcodeOk, functBad, csrBad;
  logic breakHit, ecallHit, isLoad, isStore, dcacheErr;
  logic [1:0] privMode, memSize;
  logic excValid;
  logic [3:0] excCode;
  logic [31:0] excTval;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  excCauseDetector u_dut (.*);

  task automatic idle();
    fetchPc = PC_OK; icacheErr = 0; pmaExecErr = 0; pmpExecErr = 0;
    opcodeOk = 1; functBad = 0; csrBad = 0; instrWord = INSTR_V;
    breakHit = 0; ecallHit = 0; privMode = 2'd3; memSize = 2'd2;
    memAddr = ADDR_OK; isLoad = 0; isStore = 0; dcacheErr = 0;
  endtask

  task automatic chk(input string req, input logic v, input logic [3:0] c, input logic [31:0] t);
    #1;
    checks++;
    if (excValid !== v || excCode !== c || excTval !== t) begin
      fails++;
      $display("FAIL %s: got valid=%0b code=%0d tval=%h, expected valid=%0b code=%0d tval=%h",
               req, excValid, excCode, excTval, v, c, t);
    end
  endtask

  // turn on one condition by priority index (0 highest)
  task automatic raise(input int k);
    case (k)
      0: fetchPc  = PC_OK | 32'h1;
      1: icacheErr = 1;
      2: functBad = 1;
      3: breakHit = 1;
      4: begin isLoad = 1; memAddr = ADDR_OK | 32'h2; end
      5: begin isLoad = 1; dcacheErr = 1; end
      6: begin isStore = 1; memAddr = ADDR_OK | 32'h2; end
      7: begin isStore = 1; dcacheErr = 1; end
      default: begin ecallHit = 1; privMode = 2'd1; end
    endcase
  endtask

  // expected winner from the requirement list, evaluated on current stimulus
  task automatic expectNow(output logic [3:0] c, output logic [31:0] t);
    logic dm;
    dm = (memSize == 2'd0) ? 1'b0 : (memSize == 2'd1) ? memAddr[0] :
         (memSize == 2'd2) ? (memAddr[1:0] != 2'b00) : 1'b1;
    if (fetchPc[0])                          begin c = 0; t = fetchPc; end
    else if (icacheErr|pmaExecErr|pmpExecErr) begin c = 1; t = fetchPc; end
    else if (!opcodeOk|functBad|csrBad)      begin c = 2; t = instrWord; end
    else if (breakHit)                       begin c = 3; t = 0; end
    else if (isLoad && dm)                   begin c = 4; t = memAddr; end
    else if (isLoad && dcacheErr)            begin c = 5; t = memAddr; end
    else if (isStore && dm)                  begin c = 6; t = memAddr; end
    else if (isStore && dcacheErr)           begin c = 7; t = memAddr; end
    else if (ecallHit) begin
      c = (privMode == 0) ? 4'd8 : (privMode == 1) ? 4'd9 : 4'd11; t = 0;
    end else begin c = 15; t = 0; end
  endtask

  task automatic tIdle();
    idle(); chk("R10 idle", 0, 4'd15, 32'h0);
    memSize = 2'd0; memAddr = 32'h3; chk("R10 unaligned addr without access", 0, 4'd15, 32'h0);
  endtask

  task automatic tFetchAlign();
    idle(); fetchPc = 32'h0000_1002; chk("R1 halfword-aligned PC accepted", 0, 4'd15, 0);
    fetchPc = 32'h0000_1003; chk("R1 odd PC", 1, 4'd0, 32'h0000_1003);
    fetchPc = 32'h8000_0001; chk("R1 odd PC high", 1, 4'd0, 32'h8000_0001);
  endtask

  task automatic tFetchAccess();
    idle(); icacheErr = 1;  chk("R2 cache error", 1, 4'd1, PC_OK);
    idle(); pmaExecErr = 1; chk("R2 region not executable", 1, 4'd1, PC_OK);
    idle(); pmpExecErr = 1; chk("R2 execute denied", 1, 4'd1, PC_OK);
  endtask

  task automatic tIllegal();
    idle(); opcodeOk = 0; chk("R3 bad opcode", 1, 4'd2, INSTR_V);
    idle(); functBad = 1; instrWord = 32'hFFFF_FFFF; chk("R3 bad funct", 1, 4'd2, 32'hFFFF_FFFF);
    idle(); csrBad = 1; chk("R3 csr violation", 1, 4'd2, INSTR_V);
  endtask

  task automatic tBreak();
    idle(); breakHit = 1; chk("R4 breakpoint", 1, 4'd3, 0);
  endtask

  task automatic tDataAlign();
    for (int dir = 0; dir < 2; dir++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int lo = 0; lo < 4; lo++) begin
          logic mis;
          idle();
          isLoad = (dir == 0); isStore = (dir == 1);
          memSize = 2'(sz); memAddr = 32'h0000_4440 | 32'(lo);
          mis = (sz == 0) ? 1'b0 : (sz == 1) ? (lo % 2 == 1) : (sz == 2) ? (lo != 0) : 1'b1;
          if (mis) chk("R5 R9 misaligned data", 1, (dir == 0) ? 4'd4 : 4'd6, memAddr);
          else     chk("R5 aligned data", 0, 4'd15, 0);
        end
      end
    end
  endtask

  task automatic tDataFault();
    idle(); isLoad = 1; dcacheErr = 1; memAddr = 32'h0000_5554;
    chk("R6 R9 load fault", 1, 4'd5, 32'h0000_5554);
    idle(); isStore = 1; dcacheErr = 1; memAddr = 32'h0000_6668;
    chk("R6 R9 store fault", 1, 4'd7, 32'h0000_6668);
    idle(); dcacheErr = 1; chk("R6 error without access ignored", 0, 4'd15, 0);
  endtask

  task automatic tEcall();
    idle(); ecallHit = 1; privMode = 2'd0; chk("R7 user ecall", 1, 4'd8, 0);
    privMode = 2'd1; chk("R7 supervisor ecall", 1, 4'd9, 0);
    privMode = 2'd3; chk("R7 machine ecall", 1, 4'd11, 0);
    privMode = 2'd2; chk("R7 unused privilege", 1, 4'd11, 0);
  endtask

  task automatic tPairs();
    for (int i = 0; i < 9; i++) begin
      for (int j = i + 1; j < 9; j++) begin
        logic [3:0] c; logic [31:0] t;
        idle(); raise(i); raise(j); expectNow(c, t);
        if (c > 4'(i) && !(i == 6 && j == 7)) begin
          checks++; fails++;
          $display("FAIL R8 bench pairing %0d/%0d: got code=%0d expected code<=%0d", i, j, c, i);
        end
        chk("R8 pair priority", 1, c, t);
      end
    end
  endtask

  initial begin
    idle();
    tIdle(); tFetchAlign(); tFetchAccess(); tIllegal(); tBreak();
    tDataAlign(); tDataFault(); tEcall(); tPairs();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule